// File: doc/BRIEF.md
# Next-PC and Branch Alignment Unit

This block holds the program counter of an integer core whose instructions are all 32 bits wide and word aligned. Each cycle it is told what kind of control transfer the current instruction performs, whether a conditional branch resolved as taken, and the target address already computed elsewhere. From these it picks the next program counter and loads it into the PC register on the following clock edge. The choices are the sequential address, the target, or the current address held in place when a fault occurs.

A taken transfer whose target is not on a four-byte boundary raises an instruction-address-misaligned fault. The fault is charged to the branch or jump itself. The PC is not redirected, the faulting instruction's address appears on the exception-PC output, and the offending target appears on the trap-value output, so trap logic outside the block can take over. Register-indirect jumps have target bit 0 forced low before the check, so only bit 1 can make them fault. The PC width is set by the parameter XLEN (32 or 64), and a synchronous active-high reset loads the parameter RESET_VEC.

Top module: `npc_align_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC register loads RESET_VEC, and `pc_o` shows it after that edge.
- R2: Transfer kind 2'b00 (none) gives `taken_o`=0 and `next_pc_o`=`pc_o`+4. The PC takes that value at the next edge.
- R3: Kind 2'b01 (conditional branch) with `cond_i`=1 gives `taken_o`=1 and `next_pc_o`=`target_i` when the target is aligned. With `cond_i`=0 it gives `taken_o`=0 and `next_pc_o`=`pc_o`+4.
- R4: Kind 2'b10 (direct jump) is always taken, whatever `cond_i` is. With an aligned target, `next_pc_o`=`target_i`.
- R5: Kind 2'b11 (register-indirect jump) is always taken, and its effective target is `target_i` with bit 0 cleared. A target whose only low-order bit set is bit 0 does not fault, and `next_pc_o` is `target_i` & ~1.
- R6: `misalign_o`=1 exactly when the transfer is taken and bits [1:0] of the effective target are nonzero. For kind 2'b11 this means bit 1 is set.
- R7: When `misalign_o`=1, `next_pc_o` equals `pc_o`, and the PC register keeps its value across the next edge.
- R8: When `misalign_o`=1, `epc_o` equals `pc_o` and `tval_o` equals the effective target. When `misalign_o`=0, both outputs are zero.
- R9: A conditional branch with `cond_i`=0 never raises `misalign_o`, even when its target is misaligned.
- R10: The sequential address wraps modulo 2^XLEN: from PC 2^XLEN-4 with kind 2'b00, the next PC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 2 | Transfer kind: 00 none, 01 conditional branch, 10 direct jump, 11 register-indirect jump |
| cond_i | input | 1 | Resolved branch condition (1 = taken) |
| target_i | input | XLEN | Computed transfer target |
| pc_o | output | XLEN | Current program counter |
| next_pc_o | output | XLEN | Program counter to be loaded at the next edge |
| taken_o | output | 1 | Transfer is taken |
| misalign_o | output | 1 | Instruction-address-misaligned fault |
| epc_o | output | XLEN | Address of the faulting instruction (zero when no fault) |
| tval_o | output | XLEN | Misaligned target value (zero when no fault) |

## Verification
The hardest cases to reach are the ones where a fault signal has to stay low even though the target looks bad. One is a branch that is not taken but carries a misaligned target. The other is an indirect jump whose target is odd only in bit 0. The bench applies both deliberately and checks that the PC advances normally.

The bench also checks that a fault keeps the PC in place. It first jumps to a known address, then applies a faulting transfer across a clock edge and confirms that `pc_o` has not moved. Wraparound of the sequential address is reached by first jumping to the top word of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        XFER_NONE     = 2'b00,
        XFER_BRANCH   = 2'b01,
        XFER_JUMP     = 2'b10,
        XFER_INDIRECT = 2'b11
    } xfer_kind_e;

endpackage

// File: rtl/npc_target_fix.sv
module npc_target_fix
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_kind_e        kind_i,
    input  logic [XLEN-1:0]   target_i,
    output logic [XLEN-1:0]   eff_target_o,
    output logic              low_bad_o
);

    // Indirect jumps drop target bit 0; every kind then requires bits [1:0] clear.
    always_comb begin
        eff_target_o = target_i;
        if (kind_i == XFER_INDIRECT) begin
            eff_target_o[0] = 1'b0;
        end
        low_bad_o = |eff_target_o[1:0];
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_kind_e        kind_i,
    input  logic              cond_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   eff_target_i,
    input  logic              low_bad_i,
    output logic              taken_o,
    output logic              fault_o,
    output logic [XLEN-1:0]   next_pc_o
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    always_comb begin
        unique case (kind_i)
            XFER_NONE:     taken_o = 1'b0;
            XFER_BRANCH:   taken_o = cond_i;
            XFER_JUMP:     taken_o = 1'b1;
            XFER_INDIRECT: taken_o = 1'b1;
            default:       taken_o = 1'b0;
        endcase

        fault_o = taken_o && low_bad_i;

        if (fault_o) begin
            next_pc_o = pc_i;
        end else if (taken_o) begin
            next_pc_o = eff_target_i;
        end else begin
            next_pc_o = pc_i + INSN_BYTES;
        end
    end

endmodule

// File: rtl/npc_align_unit.sv
module npc_align_unit
    import npc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_1000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        kind_i,
    input  logic              cond_i,
    input  logic [XLEN-1:0]   target_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              misalign_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   tval_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t          state_d;
    state_t          state_q;
    xfer_kind_e      kind;
    logic [XLEN-1:0] eff_target;
    logic            low_bad;
    logic            taken;
    logic            fault;
    logic [XLEN-1:0] sel_pc;

    assign kind = xfer_kind_e'(kind_i);

    npc_target_fix #(.XLEN(XLEN)) u_fix (
        .kind_i       (kind),
        .target_i     (target_i),
        .eff_target_o (eff_target),
        .low_bad_o    (low_bad)
    );

    npc_select #(.XLEN(XLEN)) u_sel (
        .kind_i       (kind),
        .cond_i       (cond_i),
        .pc_i         (state_q.pc),
        .eff_target_i (eff_target),
        .low_bad_i    (low_bad),
        .taken_o      (taken),
        .fault_o      (fault),
        .next_pc_o    (sel_pc)
    );

    always_comb begin
        state_d    = state_q;
        state_d.pc = sel_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.pc <= RESET_VEC;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o       = state_q.pc;
    assign next_pc_o  = sel_pc;
    assign taken_o    = taken;
    assign misalign_o = fault;
    assign epc_o      = fault ? state_q.pc : '0;
    assign tval_o     = fault ? eff_target : '0;

endmodule

// File: rtl/npc_align_unit_chk.sv
module npc_align_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      kind_i,
    input logic            cond_i,
    input logic [XLEN-1:0] target_i,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic            misalign_o,
    input logic [XLEN-1:0] epc_o,
    input logic [XLEN-1:0] tval_o
);

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b00) |=> (pc_o == $past(pc_o) + XLEN'(4))); // R2

    AST_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        misalign_o |=> (pc_o == $past(pc_o))); // R7

    AST_UNTAKEN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b01 && !cond_i) |-> !misalign_o); // R9

    AST_EPC_IS_PC: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (epc_o == pc_o)); // R8

    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (kind_i[1]) |-> taken_o); // R4

    AST_TARGET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (taken_o && !misalign_o) |=>
            (pc_o[XLEN-1:1] == $past(target_i[XLEN-1:1]))); // R3

    AST_QUIET_TRAPVAL: assert property (@(posedge clk) disable iff (rst)
        !misalign_o |-> (tval_o == '0 && epc_o == '0)); // R8

    AST_NEXT_HELD: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (next_pc_o == pc_o)); // R7

endmodule

bind npc_align_unit npc_align_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .kind_i     (kind_i),
    .cond_i     (cond_i),
    .target_i   (target_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .misalign_o (misalign_o),
    .epc_o      (epc_o),
    .tval_o     (tval_o)
);

// File: tb/npc_align_unit_tb.sv
module npc_align_unit_tb;

    localparam int          XLEN     = 32;
    localparam int          CLK_HALF = 5;
    localparam logic [31:0] RVEC     = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  kind_i;
    logic        cond_i;
    logic [31:0] target_i;
    logic [31:0] pc_o, next_pc_o, epc_o, tval_o;
    logic        taken_o, misalign_o;

    int n_run  = 0;
    int n_fail = 0;

    always #CLK_HALF clk = ~clk;

    npc_align_unit #(.XLEN(XLEN), .RESET_VEC(RVEC)) u_dut (
        .clk(clk), .rst(rst), .kind_i(kind_i), .cond_i(cond_i),
        .target_i(target_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .misalign_o(misalign_o),
        .epc_o(epc_o), .tval_o(tval_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply inputs just after a falling edge and let them settle.
    task automatic drive(input logic [1:0] k, input logic c, input logic [31:0] t);
        @(negedge clk);
        kind_i = k; cond_i = c; target_i = t;
        #1;
    endtask

    task automatic clock_in;
        @(posedge clk);
        #1;
    endtask

    // Put the PC at an aligned address with a direct jump.
    task automatic go_to(input logic [31:0] a);
        drive(2'b10, 1'b0, a);
        clock_in();
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(2'b10, 1'b0, 32'h0000_0080);
        clock_in();
        chk("R1 reset pc", pc_o, RVEC);
        clock_in();
        chk("R1 reset held", pc_o, RVEC);
        rst = 1'b0;
    endtask

    task automatic t_sequential;
        logic [31:0] p;
        p = pc_o;
        drive(2'b00, 1'b1, 32'h0000_0003);
        chk("R2 taken", {31'b0, taken_o}, 32'd0);
        chk("R2 next", next_pc_o, p + 32'd4);
        chk("R2 no fault", {31'b0, misalign_o}, 32'd0);
        clock_in();
        chk("R2 pc", pc_o, p + 32'd4);
    endtask

    task automatic t_branch;
        logic [31:0] p;
        drive(2'b01, 1'b1, 32'h0000_2000);
        chk("R3 taken", {31'b0, taken_o}, 32'd1);
        chk("R3 next", next_pc_o, 32'h0000_2000);
        clock_in();
        chk("R3 pc", pc_o, 32'h0000_2000);
        p = pc_o;
        drive(2'b01, 1'b0, 32'h0000_3000);
        chk("R3 untaken flag", {31'b0, taken_o}, 32'd0);
        clock_in();
        chk("R3 untaken pc", pc_o, p + 32'd4);
    endtask

    task automatic t_jump;
        drive(2'b10, 1'b0, 32'h0000_4440);
        chk("R4 taken cond0", {31'b0, taken_o}, 32'd1);
        chk("R4 next", next_pc_o, 32'h0000_4440);
        clock_in();
        chk("R4 pc", pc_o, 32'h0000_4440);
    endtask

    task automatic t_indirect_bit0;
        drive(2'b11, 1'b0, 32'h0000_5001);
        chk("R5 no fault", {31'b0, misalign_o}, 32'd0);
        chk("R5 next", next_pc_o, 32'h0000_5000);
        clock_in();
        chk("R5 pc", pc_o, 32'h0000_5000);
    endtask

    task automatic t_fault(input logic [1:0] k, input logic [31:0] t,
                           input logic [31:0] eff, input string tag);
        logic [31:0] p;
        go_to(32'h0000_6000);
        p = pc_o;
        drive(k, 1'b1, t);
        chk({"R6 flag ", tag}, {31'b0, misalign_o}, 32'd1);
        chk({"R7 next ", tag}, next_pc_o, p);
        chk({"R8 epc ", tag}, epc_o, p);
        chk({"R8 tval ", tag}, tval_o, eff);
        clock_in();
        chk({"R7 held ", tag}, pc_o, p);
    endtask

    task automatic t_untaken_bad;
        logic [31:0] p;
        p = pc_o;
        drive(2'b01, 1'b0, 32'h0000_7002);
        chk("R9 no fault", {31'b0, misalign_o}, 32'd0);
        chk("R9 epc zero", epc_o, 32'd0);
        chk("R9 tval zero", tval_o, 32'd0);
        clock_in();
        chk("R9 pc", pc_o, p + 32'd4);
    endtask

    task automatic t_wrap;
        go_to(32'hFFFF_FFFC);
        chk("R10 at top", pc_o, 32'hFFFF_FFFC);
        drive(2'b00, 1'b0, 32'h0);
        clock_in();
        chk("R10 wrap", pc_o, 32'h0000_0000);
    endtask

    initial begin
        kind_i = 2'b00; cond_i = 1'b0; target_i = '0; rst = 1'b1;
        t_reset();
        t_sequential();
        t_branch();
        t_jump();
        t_indirect_bit0();
        t_fault(2'b01, 32'h0000_8002, 32'h0000_8002, "branch b1");
        t_fault(2'b10, 32'h0000_8001, 32'h0000_8001, "jump b0");
        t_fault(2'b11, 32'h0000_8003, 32'h0000_8002, "indirect b1");
        t_untaken_bad();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 5000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule